// File: doc/BRIEF.md
# Packet Buffer Copy and Checksum Engine

This engine moves or inspects bytes held in the shared 8-Kbyte packet memory. It reaches that memory through one request/grant port, the same arbiter channel that the transmit path uses. The engine has two operating modes, chosen when a job starts.

In copy mode it reads a source range one byte at a time and writes each byte to a destination area. In sum mode it only reads the source range and builds a 16-bit one's-complement sum. Source reads follow the receive-ring rule: a read pointer that steps past the ring's upper bound continues at the ring's lower bound. Destination writes step linearly through the whole address space and ignore the ring.

The source bounds, the destination, the ring bounds and the mode are sampled on a start pulse. A one-cycle done pulse marks the end of the job.

Top module: `buf_dma_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are low and `csum_o` is zero.
- R2: With `mode_i`=1 (sum mode) the engine issues read requests only, so `mem_we_o` is never high while `mem_req_o` is high.
- R3: In sum mode, `csum_o` at done equals the end-around-carry sum of the source bytes taken as big-endian 16-bit words. The byte at even offset from the start is the high byte. An odd last byte is padded with a zero low byte. The result is not complemented. In copy mode `csum_o` reads zero at done.
- R4: Source reads begin at `src_start_i` and end with `src_end_i`, which is inclusive. After each read the address becomes `ring_lo_i` if it equalled `ring_hi_i`, and otherwise the address plus one, modulo 8192.
- R5: With `mode_i`=0 (copy mode), each byte read is written before the next read. The k-th write goes to `dst_i`+k modulo 8192, with no ring wrap, and carries the k-th byte read.
- R6: A request holds its address, write enable and write data until it is granted. Pointers advance only on a granted access, and the read data is taken in the cycle after the grant.
- R7: `busy_o` is high from the cycle after an accepted start until the job ends. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. `mem_req_o` is high only while busy.
- R8: A start pulse while busy is ignored. The running job's addresses, data and checksum are unchanged.
- R9: When the ring successor of `src_end_i` equals `src_start_i` (an empty range), `done_o` rises in the cycle after the start pulse. No request is made, and `csum_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| mode_i | input | 1 | 0 copy, 1 sum |
| src_start_i | input | 13 | First source address |
| src_end_i | input | 13 | Last source address, inclusive |
| dst_i | input | 13 | First destination address |
| ring_lo_i | input | 13 | Receive ring lower bound, inclusive |
| ring_hi_i | input | 13 | Receive ring upper bound, inclusive |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 13 | Access address |
| mem_wdata_o | output | 8 | Write byte |
| mem_gnt_i | input | 1 | Grant for the current request |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after a read grant |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| csum_o | output | 16 | One's-complement sum result |

## Verification
The riskiest overlap is a withheld grant that lands on the very cycle in which the read pointer sits on the ring's upper bound. In that cycle the wrap step and the hold rule act on the same register. The bench provokes this by sweeping start offsets across the ring, with lengths up to the ring size, under a pseudo-random grant pattern. Each read address it logs is compared with the wrapped sequence the bench computes. The byte written, or the sum built from those reads, must also match the bench's own arithmetic.

// File: rtl/buf_dma_pkg.sv
// Shared definitions for the packet-buffer copy/checksum engine.
// Assumes byte-wide memory and a 16-bit checksum built from byte pairs.
package buf_dma_pkg;
    localparam int BYTE_W = 8;
    localparam int SUM_W  = 2 * BYTE_W;

    localparam logic MODE_COPY = 1'b0;
    localparam logic MODE_SUM  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_TAKE,
        ST_WRITE
    } dma_state_e;
endpackage

// File: rtl/buf_dma_addr_step.sv
// Next-address stepper for a bounded ring: it returns lo_i after hi_i and cur_i+1 otherwise.
// Assumes lo_i/hi_i are inclusive. With lo_i=0 and hi_i=all ones it acts as a plain linear increment.
module buf_dma_addr_step #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    output logic [ADDR_W-1:0] nxt_o
);
    // Select wrap target or increment.
    always_comb begin
        if (cur_i == hi_i) nxt_o = lo_i;
        else               nxt_o = cur_i + ADDR_W'(1);
    end
endmodule

// File: rtl/buf_dma_csum_add.sv
// Adds one byte into a 16-bit one's-complement accumulator.
// The byte goes to the high lane when low_lane_i is 0, which gives big-endian word order.
// Assumes that adding bytes lane by lane gives the same result as adding whole words, since end-around addition is associative.
module buf_dma_csum_add
    import buf_dma_pkg::*;
(
    input  logic [SUM_W-1:0]  acc_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              low_lane_i,
    output logic [SUM_W-1:0]  sum_o
);
    logic [SUM_W-1:0] word;
    logic [SUM_W:0]   raw;

    // Place the byte in its lane, then fold the carry back in.
    always_comb begin
        word  = low_lane_i ? {{BYTE_W{1'b0}}, byte_i} : {byte_i, {BYTE_W{1'b0}}};
        raw   = {1'b0, acc_i} + {1'b0, word};
        sum_o = raw[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, raw[SUM_W]};
    end
endmodule

// File: rtl/buf_dma_engine.sv
// Copy/checksum engine on the shared packet buffer.
// Source reads wrap inside the receive ring; destination writes step linearly.
// One access is outstanding at a time. Read data is expected one cycle after a read grant.
// Parameters are sampled on an accepted start pulse.
module buf_dma_engine
    import buf_dma_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] src_start_i,
    input  logic [ADDR_W-1:0] src_end_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [ADDR_W-1:0] ring_lo_i,
    input  logic [ADDR_W-1:0] ring_hi_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SUM_W-1:0]  csum_o
);
    localparam logic [ADDR_W-1:0] LIN_LO = '0;
    localparam logic [ADDR_W-1:0] LIN_HI = '1;

    dma_state_e        state_q;
    logic              csum_mode_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [ADDR_W-1:0] end_q;
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic              last_q;
    logic [BYTE_W-1:0] byte_q;
    logic              lane_q;
    logic [SUM_W-1:0]  acc_q;
    logic              done_q;

    logic [ADDR_W-1:0] rd_next;
    logic [ADDR_W-1:0] wr_next;
    logic [ADDR_W-1:0] end_succ;
    logic              empty_w;
    logic [SUM_W-1:0]  sum_w;

    // Source stepper: wraps within the latched ring.
    buf_dma_addr_step #(.ADDR_W(ADDR_W)) u_rd_step (
        .cur_i(rd_ptr_q), .lo_i(lo_q), .hi_i(hi_q), .nxt_o(rd_next)
    );

    // Destination stepper: the ring covers the whole space, so it never wraps early.
    buf_dma_addr_step #(.ADDR_W(ADDR_W)) u_wr_step (
        .cur_i(wr_ptr_q), .lo_i(LIN_LO), .hi_i(LIN_HI), .nxt_o(wr_next)
    );

    // Empty-range test: the range is empty when the successor of its end is its start.
    buf_dma_addr_step #(.ADDR_W(ADDR_W)) u_empty_step (
        .cur_i(src_end_i), .lo_i(ring_lo_i), .hi_i(ring_hi_i), .nxt_o(end_succ)
    );

    // Checksum adder for the byte just returned by memory.
    buf_dma_csum_add u_csum (
        .acc_i(acc_q), .byte_i(mem_rdata_i), .low_lane_i(lane_q), .sum_o(sum_w)
    );

    assign empty_w = (end_succ == src_start_i);

    // Transfer sequencer: accept jobs, step through the read/take/write phases, and signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            csum_mode_q <= MODE_COPY;
            rd_ptr_q    <= '0;
            end_q       <= '0;
            wr_ptr_q    <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            last_q      <= 1'b0;
            byte_q      <= '0;
            lane_q      <= 1'b0;
            acc_q       <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        csum_mode_q <= mode_i;
                        rd_ptr_q    <= src_start_i;
                        end_q       <= src_end_i;
                        wr_ptr_q    <= dst_i;
                        lo_q        <= ring_lo_i;
                        hi_q        <= ring_hi_i;
                        lane_q      <= 1'b0;
                        acc_q       <= '0;
                        if (empty_w) done_q  <= 1'b1;
                        else         state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_gnt_i) begin
                        last_q   <= (rd_ptr_q == end_q);
                        rd_ptr_q <= rd_next;
                        state_q  <= ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (csum_mode_q == MODE_SUM) begin
                        acc_q  <= sum_w;
                        lane_q <= ~lane_q;
                        if (last_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end else begin
                        byte_q  <= mem_rdata_i;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt_i) begin
                        wr_ptr_q <= wr_next;
                        if (last_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port and status outputs, decoded from the state.
    always_comb begin
        mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we_o    = (state_q == ST_WRITE);
        mem_addr_o  = (state_q == ST_WRITE) ? wr_ptr_q : rd_ptr_q;
        mem_wdata_o = byte_q;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        csum_o      = acc_q;
    end
endmodule

// File: rtl/buf_dma_engine_chk.sv
// Property checker for buf_dma_engine, attached through bind.
// It observes the memory port, the status outputs and the latched mode.
module buf_dma_engine_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              req,
    input logic              we,
    input logic              gnt,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              csum_mode
);
    // R2: sum mode never writes.
    assert_sum_reads_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req && csum_mode |-> !we);

    // R5: a granted write is never followed at once by another write.
    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && gnt |=> !(req && we));

    // R6: an ungranted request holds steady.
    assert_hold_until_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req && !gnt |=> req && $stable(addr) && $stable(we) && $stable(wdata));

    // R7: done lasts one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy is low in the done cycle.
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: requests are made only while busy.
    assert_req_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);

    // R8: the mode of a running job does not change.
    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(csum_mode));
endmodule

bind buf_dma_engine buf_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o),
    .req(mem_req_o), .we(mem_we_o), .gnt(mem_gnt_i), .addr(mem_addr_o),
    .wdata(mem_wdata_o), .csum_mode(csum_mode_q)
);

// File: tb/buf_dma_engine_tb.sv
// Sweeping bench: start offsets and lengths over a small ring, both modes, with grant stalls.
module buf_dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [12:0] src_start_i = '0, src_end_i = '0, dst_i = '0, ring_lo_i = '0, ring_hi_i = '0;
    logic        mem_req_o, mem_we_o, busy_o, done_o;
    logic [12:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_gnt_i = 1'b0;
    logic [7:0]  mem_rdata_i = '0;
    logic [15:0] csum_o;

    int checks = 0;
    int failures = 0;
    logic        clr = 1'b0;
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          rd_n = 0, wr_n = 0;
    logic [12:0] rd_addr [64];
    logic [12:0] wr_addr [64];
    logic [7:0]  wr_data [64];
    logic [12:0] exp_rd  [64];

    always #2.5 clk = ~clk;

    buf_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .src_start_i(src_start_i), .src_end_i(src_end_i), .dst_i(dst_i),
        .ring_lo_i(ring_lo_i), .ring_hi_i(ring_hi_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .csum_o(csum_o)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return 8'(a[7:0] * 8'd7 + {3'b000, a[12:8]} * 8'd29 + 8'h5A);
    endfunction

    function automatic logic [12:0] ring_next(input logic [12:0] a, input logic [12:0] lo, input logic [12:0] hi);
        return (a == hi) ? lo : 13'(a + 13'd1);
    endfunction

    function automatic logic [15:0] eac_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] r;
        r = {1'b0, a} + {1'b0, b};
        return r[15:0] + {15'd0, r[16]};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory model: logs accesses and returns read data one cycle after a read grant.
    always @(posedge clk) begin
        if (clr) begin
            rd_n <= 0;
            wr_n <= 0;
        end else if (mem_req_o && mem_gnt_i) begin
            if (mem_we_o) begin
                if (wr_n < 64) begin
                    wr_addr[wr_n] <= mem_addr_o;
                    wr_data[wr_n] <= mem_wdata_o;
                end
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata_i <= pat(mem_addr_o);
                if (rd_n < 64) rd_addr[rd_n] <= mem_addr_o;
                rd_n <= rd_n + 1;
            end
        end
    end

    // Grant generator, driven away from the active edge.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt_i <= mem_req_o && (!stall_en || lfsr[0] || lfsr[3]);
    end

    task automatic run_job(input bit sum_mode, input logic [12:0] s, input int len,
                           input logic [12:0] d, input logic [12:0] lo, input logic [12:0] hi,
                           input bit stall, input bit poke);
        logic [12:0] a, e;
        logic [15:0] exp_sum;
        int cyc;
        bit ok;
        a = s;
        exp_sum = '0;
        for (int i = 0; i < len; i++) begin
            exp_rd[i] = a;
            exp_sum = eac_add(exp_sum, (i % 2 == 0) ? {pat(a), 8'h00} : {8'h00, pat(a)});
            a = ring_next(a, lo, hi);
        end
        if (len == 0) e = (s == lo) ? hi : 13'(s - 13'd1);
        else          e = exp_rd[len-1];
        @(negedge clk);
        clr = 1'b1;
        stall_en = stall;
        @(negedge clk);
        clr = 1'b0;
        mode_i = sum_mode;
        src_start_i = s;
        src_end_i = e;
        dst_i = d;
        ring_lo_i = lo;
        ring_hi_i = hi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            cyc = 3;
            check(busy_o == 1'b1, "R7", "busy during job", int'(busy_o), 1);
            mode_i = ~sum_mode;
            src_start_i = 13'h0005;
            src_end_i = 13'h0007;
            dst_i = 13'h0A00;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(done_o == 1'b1, "R7", "done reached", int'(done_o), 1);
        check(busy_o == 1'b0, "R7", "busy low with done", int'(busy_o), 0);
        if (len == 0) begin
            check(cyc == 0, "R9", "empty range done latency", cyc, 0);
            check(rd_n == 0 && wr_n == 0, "R9", "empty range access count", rd_n + wr_n, 0);
            check(csum_o == 16'h0, "R9", "empty range sum", int'(csum_o), 0);
        end
        check(rd_n == len, "R4", "read count", rd_n, len);
        ok = 1'b1;
        for (int i = 0; i < len && i < rd_n; i++) if (rd_addr[i] != exp_rd[i]) ok = 1'b0;
        check(ok, "R4", "read address sequence", ok ? 1 : 0, 1);
        if (sum_mode) begin
            check(wr_n == 0, "R2", "writes in sum mode", wr_n, 0);
            check(csum_o == exp_sum, "R3", "checksum", int'(csum_o), int'(exp_sum));
        end else begin
            check(wr_n == len, "R5", "write count", wr_n, len);
            ok = 1'b1;
            for (int i = 0; i < len && i < wr_n; i++)
                if (wr_addr[i] != 13'(d + 13'(i)) || wr_data[i] != pat(exp_rd[i])) ok = 1'b0;
            check(ok, "R5", "write address and data", ok ? 1 : 0, 1);
            check(csum_o == 16'h0, "R3", "copy mode sum", int'(csum_o), 0);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R7", "done one cycle", int'(done_o), 0);
        if (poke) check(busy_o == 1'b0 && rd_n == len, "R8", "start while busy ignored", rd_n, len);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Stimulus: reset, then sweeps and corner jobs.
    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && mem_req_o == 1'b0, "R1", "reset outputs",
              int'({busy_o, done_o, mem_req_o}), 0);
        check(csum_o == 16'h0, "R1", "reset sum", int'(csum_o), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int si = 0; si < 8; si++)
                for (int len = 0; len < 32; len++)
                    run_job(m[0], 13'(16 + si * 5), len, 13'(13'h100 + si * 64),
                            13'd16, 13'd47, (len % 3) != 0, 1'b0);
        // R5: linear destination crossing the top of the address space, source outside the ring.
        run_job(1'b0, 13'd2, 6, 13'h1FFD, 13'd16, 13'd47, 1'b1, 1'b0);
        // R4: ring ending at the top address.
        run_job(1'b1, 13'h1FFC, 9, 13'h0, 13'h1FF4, 13'h1FFF, 1'b1, 1'b0);
        run_job(1'b0, 13'h1FFE, 7, 13'h40, 13'h1FF4, 13'h1FFF, 1'b0, 1'b0);
        // R8: start pulses during running jobs of both modes.
        run_job(1'b1, 13'd40, 20, 13'h300, 13'd16, 13'd47, 1'b1, 1'b1);
        run_job(1'b0, 13'd30, 20, 13'h300, 13'd16, 13'd47, 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule